// File: doc/BRIEF.md
# Asynchronous Byte-Handshake Bus Slave

This block is the device side of an 8-bit bidirectional parallel link to a host microcontroller. The host owns four control lines: a framing start line, a byte request line, a direction select and an active-low link reset. The slave answers on two lines: a frame acknowledge and a byte response. Each host control line passes through a synchroniser into the system clock domain before the sequencer uses it. The pad itself sits outside the block, so the bus appears as separate input, output and output-enable signals.

A transaction has a fixed shape. The host raises start and the slave raises acknowledge. The host then writes six bytes using a four-phase request/response handshake: an operation code, a register address, and a 32-bit value sent low byte first. The slave decodes the operation and performs at most one single-cycle access on its internal register port. It then returns eight bytes with the same handshake, reversed: a 32-bit data word, then a 32-bit status word, each low byte first. After the last reply byte the slave drops acknowledge. The host then drops start and the slave goes back to idle.

Top module: `hsbus_slave`

## Requirements
- R1: After system reset, `s_ack`, `s_resp` and `bus_oe` are all low.
- R2: `s_ack` rises after `m_start` is seen high. It stays high through all six write bytes and all eight reply bytes, and falls once the eighth reply byte's handshake has completed.
- R3: Write byte (`m_rw`=0): `s_resp` rises only after `m_req` is seen high, at which point `bus_in` is captured. `s_resp` falls after `m_req` is seen low. Read byte (`m_rw`=1): `s_resp` rises while `m_req` is low, and falls after `m_req` is seen high.
- R4: Write bytes arrive in this order: byte 0 is the operation code, byte 1 is the register address, bytes 2..5 are the data value, least significant byte first. Code 0x10 causes exactly one `reg_wr_en` pulse that carries that address and that value. The reply data word and the reply status word are then both 0.
- R5: Code 0x11 causes exactly one `reg_rd_en` pulse with that address and no write. The reply data word equals `reg_rdata` as presented during that pulse, and the status word is 0. The data bytes of a read are ignored.
- R6: The eight reply bytes are sent in this order: the data word in bytes 0..3, then the status word in bytes 4..7, each word least significant byte first.
- R7: Any other operation code causes no register access. It returns a data word of 0 and a status word whose low byte is the error code 0xE1, with all other bits 0.
- R8: `bus_oe` is high only while `m_rw` selects read and a reply byte is in progress. During every reply byte handshake it is high when the host samples the bus.
- R9: Driving `m_rst_n` low returns the slave to idle from any point. `s_ack` and `s_resp` fall, the partial frame is discarded, and the next transaction starts again at byte 0.
- R10: `reg_wr_en` and `reg_rd_en` are never high together. Each is high for only one cycle at a time, and only while `s_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low |
| m_start | input | 1 | Host frame start line (asynchronous) |
| m_req | input | 1 | Host byte request line (asynchronous) |
| m_rw | input | 1 | Host direction: 0 = host writes, 1 = host reads |
| m_rst_n | input | 1 | Host link reset, active low (asynchronous) |
| bus_in | input | 8 | Byte from the bus pad |
| bus_out | output | 8 | Byte driven toward the bus pad |
| bus_oe | output | 1 | Pad output enable |
| s_ack | output | 1 | Frame acknowledge to host |
| s_resp | output | 1 | Byte response to host |
| reg_wr_en | output | 1 | Register write strobe |
| reg_rd_en | output | 1 | Register read strobe |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 32 | Register write value |
| reg_rdata | input | 32 | Register read value, valid during `reg_rd_en` |

## Verification
The bench uses the default parameters: 8-bit bytes, 32-bit words, two synchroniser stages, write code 0x10, read code 0x11 and error code 0xE1. With these values every byte slot of both frames is reached, including the high data bytes and the highest status byte. Both the write and read decode paths are exercised, and random operation codes hit the error path. With two synchroniser stages, the host's own reaction delay keeps each handshake edge apart, so the bench models the host with plain wait-for-level loops. A link reset in the middle of a frame is applied to show that the byte index restarts from zero.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_WAIT,
    ST_WR_HOLD,
    ST_EXEC,
    ST_RD_SETUP,
    ST_RD_SHOW,
    ST_RD_DROP,
    ST_DONE
  } hsb_state_e;

  typedef enum logic [1:0] {
    K_WRITE,
    K_READ,
    K_BAD
  } hsb_kind_e;

  // Reply phase states: the bus may be driven only in these.
  function automatic logic is_reply_state(input hsb_state_e s);
    return (s == ST_RD_SETUP) || (s == ST_RD_SHOW) || (s == ST_RD_DROP);
  endfunction

endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/hsb_collect.sv
module hsb_collect #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 6,
  parameter int IDX_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     load,
  input  logic [IDX_W-1:0]         idx,
  input  logic [BYTE_W-1:0]        din,
  output logic [NBYTES*BYTE_W-1:0] frame
);

  for (genvar gi = 0; gi < NBYTES; gi++) begin : g_slot
    logic [BYTE_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              slot_q <= '0;
      else if (clr)                            slot_q <= '0;
      else if (load && idx == IDX_W'(gi))      slot_q <= din;
    end
    assign frame[gi*BYTE_W +: BYTE_W] = slot_q;
  end

endmodule

// File: rtl/hsb_reply.sv
module hsb_reply #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 8,
  parameter int IDX_W  = 3
) (
  input  logic [NBYTES*BYTE_W-1:0] word,
  input  logic [IDX_W-1:0]         idx,
  output logic [BYTE_W-1:0]        byte_out
);

  function automatic logic [BYTE_W-1:0] pick(input logic [NBYTES*BYTE_W-1:0] w,
                                             input logic [IDX_W-1:0] i);
    logic [BYTE_W-1:0] r;
    r = '0;
    for (int k = 0; k < NBYTES; k++)
      if (i == IDX_W'(k)) r = w[k*BYTE_W +: BYTE_W];
    return r;
  endfunction

  assign byte_out = pick(word, idx);

endmodule

// File: rtl/hsbus_slave.sv
module hsbus_slave
  import hsb_pkg::*;
#(
  parameter int                BYTE_W      = 8,
  parameter int                WORD_W      = 32,
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] CMD_WR      = 8'h10,
  parameter logic [BYTE_W-1:0] CMD_RD      = 8'h11,
  parameter logic [BYTE_W-1:0] ERR_BADCMD  = 8'hE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_start,
  input  logic              m_req,
  input  logic              m_rw,
  input  logic              m_rst_n,
  input  logic [BYTE_W-1:0] bus_in,
  output logic [BYTE_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              s_ack,
  output logic              s_resp,
  output logic              reg_wr_en,
  output logic              reg_rd_en,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  input  logic [WORD_W-1:0] reg_rdata
);

  localparam int WBYTES   = WORD_W / BYTE_W;
  localparam int WR_BYTES = 2 + WBYTES;
  localparam int RD_BYTES = 2 * WBYTES;
  localparam int MAX_B    = (RD_BYTES > WR_BYTES) ? RD_BYTES : WR_BYTES;
  localparam int IDX_W    = $clog2(MAX_B);

  // Synchronised host controls
  logic [3:0] sync_q;
  logic       rst_s, start_s, req_s, rw_s;

  hsb_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({m_rst_n, m_start, m_req, m_rw}),
    .q     (sync_q)
  );
  assign {rst_s, start_s, req_s, rw_s} = sync_q;

  hsb_state_e           state_q, state_d;
  logic [IDX_W-1:0]     idx_q;
  logic [2*WORD_W-1:0]  reply_q;
  logic [WR_BYTES*BYTE_W-1:0] frame;

  // Named internal events
  logic ev_wr_take, ev_wr_done, ev_rd_taken, ev_rd_done, ev_exec;
  logic last_wr, last_rd;
  hsb_kind_e kind;

  assign last_wr     = (idx_q == IDX_W'(WR_BYTES-1));
  assign last_rd     = (idx_q == IDX_W'(RD_BYTES-1));
  assign ev_wr_take  = (state_q == ST_WR_WAIT) && req_s && !rw_s;
  assign ev_wr_done  = (state_q == ST_WR_HOLD) && !req_s;
  assign ev_rd_taken = (state_q == ST_RD_SHOW) && req_s;
  assign ev_rd_done  = (state_q == ST_RD_DROP) && !req_s;
  assign ev_exec     = (state_q == ST_EXEC);

  function automatic hsb_kind_e decode(input logic [BYTE_W-1:0] c);
    if (c == CMD_WR)      return K_WRITE;
    else if (c == CMD_RD) return K_READ;
    else                  return K_BAD;
  endfunction

  function automatic logic [2*WORD_W-1:0] build_reply(input hsb_kind_e k,
                                                      input logic [WORD_W-1:0] rd);
    logic [WORD_W-1:0] dat, sts;
    dat = (k == K_READ) ? rd : '0;
    sts = (k == K_BAD) ? WORD_W'(ERR_BADCMD) : '0;
    return {sts, dat};
  endfunction

  assign kind      = decode(frame[0 +: BYTE_W]);
  assign reg_addr  = frame[BYTE_W +: BYTE_W];
  assign reg_wdata = frame[2*BYTE_W +: WORD_W];

  hsb_collect #(.BYTE_W(BYTE_W), .NBYTES(WR_BYTES), .IDX_W(IDX_W)) u_collect (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_q == ST_IDLE),
    .load  (ev_wr_take),
    .idx   (idx_q),
    .din   (bus_in),
    .frame (frame)
  );

  hsb_reply #(.BYTE_W(BYTE_W), .NBYTES(RD_BYTES), .IDX_W(IDX_W)) u_reply (
    .word     (reply_q),
    .idx      (idx_q),
    .byte_out (bus_out)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start_s) state_d = ST_WR_WAIT;
      ST_WR_WAIT:  if (ev_wr_take) state_d = ST_WR_HOLD;
      ST_WR_HOLD:  if (ev_wr_done) state_d = last_wr ? ST_EXEC : ST_WR_WAIT;
      ST_EXEC:     state_d = ST_RD_SETUP;
      ST_RD_SETUP: if (rw_s && !req_s) state_d = ST_RD_SHOW;
      ST_RD_SHOW:  if (ev_rd_taken) state_d = ST_RD_DROP;
      ST_RD_DROP:  if (ev_rd_done) state_d = last_rd ? ST_DONE : ST_RD_SETUP;
      ST_DONE:     if (!start_s) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
    if (!rst_s) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      reply_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_d == ST_IDLE || ev_exec)              idx_q <= '0;
      else if ((ev_wr_done && !last_wr) ||
               (ev_rd_done && !last_rd))              idx_q <= idx_q + 1'b1;
      if (ev_exec) reply_q <= build_reply(kind, reg_rdata);
    end
  end

  assign s_ack     = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign s_resp    = (state_q == ST_WR_HOLD) || (state_q == ST_RD_SHOW);
  assign bus_oe    = is_reply_state(state_q) && rw_s;
  assign reg_wr_en = ev_exec && (kind == K_WRITE);
  assign reg_rd_en = ev_exec && (kind == K_READ);

endmodule

// File: rtl/hsbus_slave_chk.sv
module hsbus_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic rst_s,
  input logic req_s,
  input logic rw_s,
  input logic s_ack,
  input logic s_resp,
  input logic bus_oe,
  input logic reg_wr_en,
  input logic reg_rd_en
);

  p_one_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en));

  p_wr_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  p_rd_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> !reg_rd_en);

  p_access_framed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en || reg_rd_en) |-> s_ack);

  p_oe_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (rw_s && s_ack));

  // Response rises on host request in write, on idle request in read
  p_resp_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_resp) |-> (req_s ^ rw_s));

  p_link_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_s |=> (!s_ack && !s_resp));

endmodule

bind hsbus_slave hsbus_slave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_s     (rst_s),
  .req_s     (req_s),
  .rw_s      (rw_s),
  .s_ack     (s_ack),
  .s_resp    (s_resp),
  .bus_oe    (bus_oe),
  .reg_wr_en (reg_wr_en),
  .reg_rd_en (reg_rd_en)
);

// File: tb/hsbus_slave_bench.sv
module hsbus_slave_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_start = 1'b0, m_req = 1'b0, m_rw = 1'b0, m_rst_n = 1'b1;
  logic [7:0]  bus_in = '0;
  logic [7:0]  bus_out;
  logic        bus_oe, s_ack, s_resp, reg_wr_en, reg_rd_en;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  int checks = 0, failures = 0;
  int wr_cnt = 0, rd_cnt = 0, oe_bad = 0;
  logic [7:0]  wr_addr_seen, rd_addr_seen;
  logic [31:0] wr_data_seen;

  always #2 clk = ~clk;

  function automatic logic [31:0] bank_val(input logic [7:0] a);
    return {a, a ^ 8'h3C, ~a, 8'h5A};
  endfunction
  assign reg_rdata = bank_val(reg_addr);

  hsbus_slave u_hsbus_slave (
    .clk(clk), .rst_n(rst_n), .m_start(m_start), .m_req(m_req), .m_rw(m_rw),
    .m_rst_n(m_rst_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .s_ack(s_ack), .s_resp(s_resp), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    if (rst_n && reg_wr_en) begin wr_cnt++; wr_addr_seen = reg_addr; wr_data_seen = reg_wdata; end
    if (rst_n && reg_rd_en) begin rd_cnt++; rd_addr_seen = reg_addr; end
  end

  always @(negedge clk)
    if (rst_n && bus_oe && (!m_rw || !s_ack)) oe_bad++;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_resp(input logic v);
    while (s_resp !== v) @(negedge clk);
  endtask

  task automatic wait_ack(input logic v);
    while (s_ack !== v) @(negedge clk);
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    bus_in = b; m_rw = 1'b0;
    @(negedge clk);
    m_req = 1'b1;
    wait_resp(1'b1);
    m_req = 1'b0;
    wait_resp(1'b0);
  endtask

  task automatic get_byte(output logic [7:0] b, output logic oe_seen);
    @(negedge clk);
    m_rw = 1'b1;
    wait_resp(1'b1);
    b = bus_out; oe_seen = bus_oe;
    m_req = 1'b1;
    wait_resp(1'b0);
    @(negedge clk);
    m_req = 1'b0;
  endtask

  task automatic run_txn(input logic [7:0] cmd, input logic [7:0] addr, input logic [31:0] val);
    logic [63:0] reply;
    logic [7:0]  b;
    logic        oe_s;
    logic        oe_all;
    logic [31:0] exp_d, exp_s;
    int w0, r0;
    w0 = wr_cnt; r0 = rd_cnt; oe_all = 1'b1;
    @(negedge clk);
    m_start = 1'b1;
    wait_ack(1'b1);
    put_byte(cmd); put_byte(addr);
    for (int i = 0; i < 4; i++) put_byte(val[i*8 +: 8]);
    for (int i = 0; i < 8; i++) begin
      get_byte(b, oe_s);
      reply[i*8 +: 8] = b;
      oe_all &= oe_s;
      if (i < 7) check("R2 ack held during reply", {63'b0, s_ack}, 64'd1);
    end
    repeat (6) @(negedge clk);
    check("R2 ack low after reply", {63'b0, s_ack}, 64'd0);
    check("R8 oe during reply", {63'b0, oe_all}, 64'd1);
    exp_d = (cmd == 8'h11) ? bank_val(addr) : 32'h0;
    exp_s = (cmd == 8'h10 || cmd == 8'h11) ? 32'h0 : 32'h0000_00E1;
    if (cmd == 8'h10) begin
      check("R4 write strobes", 64'(wr_cnt - w0), 64'd1);
      check("R4 write addr", {56'b0, wr_addr_seen}, {56'b0, addr});
      check("R4 write data", {32'b0, wr_data_seen}, {32'b0, val});
    end else if (cmd == 8'h11) begin
      check("R5 read strobes", 64'(rd_cnt - r0), 64'd1);
      check("R5 no write on read", 64'(wr_cnt - w0), 64'd0);
      check("R5 read addr", {56'b0, rd_addr_seen}, {56'b0, addr});
    end else begin
      check("R7 no access", 64'((wr_cnt - w0) + (rd_cnt - r0)), 64'd0);
    end
    check("R6 reply order data/status", reply, {exp_s, exp_d});
    m_rw = 1'b0;
    m_start = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #600000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] c;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset outputs", {61'b0, s_ack, s_resp, bus_oe}, 64'd0);

    // Directed
    run_txn(8'h10, 8'h00, 32'h0000_0000);
    run_txn(8'h10, 8'hFF, 32'hDEAD_BEEF);
    run_txn(8'h11, 8'h42, 32'hFFFF_FFFF);   // R5: data bytes ignored
    run_txn(8'h00, 8'h07, 32'h1234_5678);   // R7
    run_txn(8'hFF, 8'h80, 32'h8000_0001);   // R7

    // R9: link reset in mid frame
    @(negedge clk);
    m_start = 1'b1;
    wait_ack(1'b1);
    put_byte(8'h10); put_byte(8'h55); put_byte(8'hAA);
    m_start = 1'b0;
    m_rst_n = 1'b0;
    repeat (6) @(negedge clk);
    check("R9 ack low in link reset", {62'b0, s_ack, s_resp}, 64'd0);
    m_rst_n = 1'b1;
    repeat (6) @(negedge clk);
    run_txn(8'h10, 8'h33, 32'hCAFE_F00D);   // R9: restarts at byte 0

    // Random
    for (int n = 0; n < 24; n++) begin
      case ($urandom % 3)
        0: c = 8'h10;
        1: c = 8'h11;
        default: c = 8'($urandom);
      endcase
      run_txn(c, 8'($urandom), $urandom);
    end

    check("R8 oe only in reply with read", 64'(oe_bad), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule